// File: doc/BRIEF.md
# Serially reloadable lookup table

This block is a 16-entry, one-bit-wide lookup table addressed by a 4-bit input. When no reload is running, its output is a plain combinational function of the address. A shift port lets the whole table be rewritten while the surrounding logic stays in service. Each clock with shift enabled moves a new bit in at the bottom of the table and pushes every stored bit up by one entry. Sixteen such clocks replace the complete contents.

A built-in loader streams a 16-bit word into the table, most significant bit first, over 16 clocks. When it finishes, entry i holds bit i of the word. This makes the mapping from address to entry fixed and predictable for software that computes new coefficients, for example for a filter that adapts at run time. The top entry is brought out as a serial output so several tables can be chained into one longer shift path.

Top module: `slut_top`

## Requirements
- R1: A synchronous active-high reset clears every entry to 0 and drives `ld_busy`, `ld_done` and `chain_out` low.
- R2: The output `lut_out` equals the entry selected by `addr` (entry number = unsigned value of `addr`) in the same cycle, with no clock in between.
- R3: On a clock edge where `shift_we` is 1 and the loader is idle, entry 0 takes `shift_din` and entry i takes the old entry i-1, for every i from 1 to 15.
- R4: `chain_out` always equals entry 15. After 16 shifts, the first bit shifted in appears there.
- R5: On a clock edge where `shift_we` is 0 and the loader is idle, the table contents do not change.
- R6: A 1 on `ld_start` while idle captures `ld_word`. `ld_busy` is then high for exactly 16 cycles, starting the cycle after the start edge. During those cycles the word's bits are shifted in MSB first. Afterwards entry i equals `ld_word[i]`.
- R7: `ld_done` is high for exactly one cycle, the first cycle in which `ld_busy` is low again.
- R8: A 1 on `ld_start` while `ld_busy` is high is ignored. The running load neither restarts nor changes its word.
- R9: While `ld_busy` is high, `shift_we` and `shift_din` have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Lookup address |
| lut_out | output | 1 | Entry selected by `addr` |
| shift_we | input | 1 | Shift enable for the direct serial port |
| shift_din | input | 1 | Serial bit entering entry 0 |
| ld_word | input | 16 | Pattern for the loader; bit i ends up in entry i |
| ld_start | input | 1 | Start request for the loader |
| ld_busy | output | 1 | Loader is shifting |
| ld_done | output | 1 | One-cycle pulse when a load has finished |
| chain_out | output | 1 | Entry 15, for chaining tables |

## Verification
The bench checks the direction of the shift path one step at a time. A single 1 is walked from entry 0 up to `chain_out`, so a path that shifted the wrong way or skipped a position would show up at the wrong address. It loads asymmetric words (only the top bit set, only the bottom bit set, a mixed pattern). A loader that sent the LSB first or lost one cycle would leave the table mirrored or off by one. In the middle of a load, the bench raises a second start with an all-ones word and drives the direct shift port with ones. A design that restarted, or that let the external port in, would end with a corrupted table or a busy window longer than 16 cycles. The bench also checks the busy/done edges cycle-exactly, and checks that the table holds still through idle cycles in which the serial data toggles.

// File: rtl/slut_pkg.sv
package slut_pkg;
  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;
endpackage

// File: rtl/slut_store.sv
module slut_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_bit,
  output logic              tail_bit,
  output logic [DEPTH-1:0]  cells
);
  logic [DEPTH-1:0] cell_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           cell_q[0] <= 1'b0;
        else if (shift_en) cell_q[0] <= shift_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           cell_q[i] <= 1'b0;
        else if (shift_en) cell_q[i] <= cell_q[i-1];
      end
    end
  end

  assign rd_bit   = cell_q[addr];
  assign tail_bit = cell_q[DEPTH-1];
  assign cells    = cell_q;
endmodule

// File: rtl/slut_loader.sv
module slut_loader
  import slut_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DEPTH-1:0] word,
  output logic             busy,
  output logic             done,
  output logic             bit_out
);
  localparam int CNT_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  ld_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] pat_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      pat_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        LD_IDLE: begin
          if (start) begin
            pat_q   <= word;
            cnt_q   <= '0;
            state_q <= LD_RUN;
          end
        end
        LD_RUN: begin
          pat_q <= {pat_q[DEPTH-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= LD_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign busy    = (state_q == LD_RUN);
  assign done    = done_q;
  assign bit_out = pat_q[DEPTH-1];
endmodule

// File: rtl/slut_src_sel.sv
module slut_src_sel (
  input  logic ext_en,
  input  logic ext_bit,
  input  logic ld_active,
  input  logic ld_bit,
  output logic shift_en,
  output logic shift_in
);
  always_comb begin
    if (ld_active) begin
      shift_en = 1'b1;
      shift_in = ld_bit;
    end else begin
      shift_en = ext_en;
      shift_in = ext_bit;
    end
  end
endmodule

// File: rtl/slut_top.sv
module slut_top #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              lut_out,
  input  logic              shift_we,
  input  logic              shift_din,
  input  logic [DEPTH-1:0]  ld_word,
  input  logic              ld_start,
  output logic              ld_busy,
  output logic              ld_done,
  output logic              chain_out
);
  logic             sh_en;
  logic             sh_in;
  logic             ld_bit;
  logic [DEPTH-1:0] table_q;

  slut_loader #(.DEPTH(DEPTH)) u_loader (
    .clk     (clk),
    .rst     (rst),
    .start   (ld_start),
    .word    (ld_word),
    .busy    (ld_busy),
    .done    (ld_done),
    .bit_out (ld_bit)
  );

  slut_src_sel u_sel (
    .ext_en    (shift_we),
    .ext_bit   (shift_din),
    .ld_active (ld_busy),
    .ld_bit    (ld_bit),
    .shift_en  (sh_en),
    .shift_in  (sh_in)
  );

  slut_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sh_en),
    .shift_in (sh_in),
    .addr     (addr),
    .rd_bit   (lut_out),
    .tail_bit (chain_out),
    .cells    (table_q)
  );
endmodule

// File: rtl/slut_checker.sv
module slut_checker #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_we,
  input logic             shift_din,
  input logic             ld_busy,
  input logic             ld_done,
  input logic [DEPTH-1:0] table_q
);
  localparam int RUN_W = $clog2(DEPTH) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (ld_busy) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_we && !ld_busy) |=> table_q == {$past(table_q[DEPTH-2:0]), $past(shift_din)});

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!shift_we && !ld_busy) |=> $stable(table_q));

  p_busy_max_r6: assert property (@(posedge clk) disable iff (rst)
    ld_busy |-> run_q < RUN_W'(DEPTH));

  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ld_busy) |-> run_q == RUN_W'(DEPTH));

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> (!ld_busy && $past(ld_busy)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> !ld_done);
endmodule

bind slut_top slut_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_we  (shift_we),
  .shift_din (shift_din),
  .ld_busy   (ld_busy),
  .ld_done   (ld_done),
  .table_q   (table_q)
);

// File: tb/slut_top_bench.sv
module slut_top_bench;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  localparam int K_LUT   = 0;
  localparam int K_CHAIN = 1;
  localparam int K_BUSY  = 2;
  localparam int K_DONE  = 3;

  typedef struct {
    int    kind;
    logic  exp;
    string tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic             lut_out;
  logic             shift_we = 1'b0;
  logic             shift_din = 1'b0;
  logic [DEPTH-1:0] ld_word = '0;
  logic             ld_start = 1'b0;
  logic             ld_busy;
  logic             ld_done;
  logic             chain_out;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  slut_top #(.DEPTH(DEPTH)) u_slut_top (
    .clk (clk), .rst (rst), .addr (addr), .lut_out (lut_out),
    .shift_we (shift_we), .shift_din (shift_din),
    .ld_word (ld_word), .ld_start (ld_start),
    .ld_busy (ld_busy), .ld_done (ld_done), .chain_out (chain_out)
  );

  // monitor: compares queued expectations just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic  act;
        it = sb_q.pop_front();
        case (it.kind)
          K_LUT:   act = lut_out;
          K_CHAIN: act = chain_out;
          K_BUSY:  act = ld_busy;
          default: act = ld_done;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d addr=%0d actual=%b expected=%b",
                   it.tag, it.kind, addr, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_lut(input int a, input logic e, input string tag);
    @(negedge clk);
    addr = AW'(a);
    push(K_LUT, e, tag);
  endtask

  task automatic verify_all(input logic [DEPTH-1:0] w, input string tag);
    for (int a = 0; a < DEPTH; a++) expect_lut(a, w[a], tag);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    shift_we = 1'b1; shift_din = b;
    @(negedge clk);
    shift_we = 1'b0; shift_din = 1'b0;
  endtask

  task automatic run_load(input logic [DEPTH-1:0] w, input bit noisy);
    @(negedge clk);
    ld_word = w; ld_start = 1'b1;
    @(negedge clk);
    ld_start = 1'b0;
    push(K_BUSY, 1'b1, "R6 busy after start");
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (noisy && k == 3) begin
        ld_start = 1'b1; ld_word = '1; shift_we = 1'b1; shift_din = 1'b1;
      end
      if (noisy && k == 4) ld_start = 1'b0;
      if (noisy && k == 8) begin shift_we = 1'b0; shift_din = 1'b0; end
      if (k == 10) push(K_BUSY, 1'b1, "R8 still busy mid-load");
    end
    push(K_BUSY, 1'b0, "R6 busy ends after 16");
    push(K_DONE, 1'b1, "R7 done on finish");
    @(negedge clk);
    push(K_DONE, 1'b0, "R7 done single cycle");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    push(K_BUSY, 1'b0, "R1 busy");
    push(K_DONE, 1'b0, "R1 done");
    push(K_CHAIN, 1'b0, "R1 chain");
    verify_all('0, "R1 cleared");

    // R3/R2: walk a single 1 up the table
    shift_bit(1'b1);
    expect_lut(0, 1'b1, "R3 entry0 takes din");
    expect_lut(1, 1'b0, "R3 entry1");
    shift_bit(1'b0);
    expect_lut(1, 1'b1, "R3 moved up");
    expect_lut(0, 1'b0, "R3 entry0 new din");
    for (int k = 0; k < 14; k++) shift_bit(1'b0);
    expect_lut(15, 1'b1, "R2 addr15");
    @(negedge clk); push(K_CHAIN, 1'b1, "R4 chain after 16 shifts");
    shift_bit(1'b0);
    @(negedge clk); push(K_CHAIN, 1'b0, "R4 chain shifted out");

    // R6: loader patterns
    run_load(16'h8000, 1'b0);
    verify_all(16'h8000, "R6 msb only");
    @(negedge clk); push(K_CHAIN, 1'b1, "R4 chain after load");
    run_load(16'h0001, 1'b0);
    verify_all(16'h0001, "R6 lsb only");
    run_load(16'hA5C3, 1'b0);
    verify_all(16'hA5C3, "R6 mixed");

    // R5: idle with toggling data, write enable low
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); shift_din = ~shift_din;
    end
    shift_din = 1'b0;
    verify_all(16'hA5C3, "R5 hold");

    // R8/R9: restart and external shift during a load are ignored
    run_load(16'h3C96, 1'b1);
    verify_all(16'h3C96, "R8 R9 noisy load");

    run_load(16'h0000, 1'b0);
    verify_all(16'h0000, "R6 zero word");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule